// File: doc/BRIEF.md
# Memory-Mapped Configurable I/O Port

This block is a general-purpose pin port that a microcontroller reaches through a window of four byte-wide registers. Each pin works in one of three modes. In microcontroller I/O mode the port extends the controller's own pins. In logic-array mode an external programmable logic array supplies the output value and, on chosen pins, an output-enable term. In address-output mode the pins carry a nibble of a bus address byte that is captured when the address latch enable falls.

Two build-time masks set the wiring. One says which pins have a logic-array output. The other says which pins have a logic-array enable term. A per-nibble parameter chooses which half of the captured address byte each pin nibble carries. A build-time switch can leave out the mode register, and the port is then fixed in microcontroller I/O mode. The block gives a value and an enable for each pin's tri-state pad. It also samples the pad levels once per clock so the controller can read them.

Top module: `cfg_io_port`

## Requirements
- R1: After a synchronous active-low reset, the Control, Data Out and Direction registers read 0. Every pin without an enable term then has pad_oe low.
- R2: A write takes effect on the rising clock edge when cs and wr are both high. The register is picked by addr: 1 is Control, 2 is Data Out, 3 is Direction. The register reads back its new value from the next cycle on.
- R3: Offset 0 returns the pad_in value sampled at the previous rising edge. A write to offset 0 changes no register.
- R4: A Control bit of 0 puts the pin in microcontroller I/O mode, where pad_out is that pin's Data Out bit. On a pin without an enable term, pad_oe equals that pin's Direction bit (1 drives, 0 is input).
- R5: In microcontroller I/O mode, a pin that has an enable term (OE_DEF bit set) takes pad_oe from pld_oe.
- R6: A Control bit of 1 on a pin with a logic-array output (ARR_DEF bit set) gives pad_out equal to pld_out. pad_oe is then the Direction bit ANDed with pld_oe where an enable term exists. A Direction bit of 0 always tri-states the pin.
- R7: A Control bit of 1 on a pin without a logic-array output puts it in address-output mode with pad_oe high. Its pad_out takes the captured address bit of the same position within the chosen half. That half is the high nibble (bits 7:4) when the pin nibble's NIB_HI bit is 1, and the low nibble (bits 3:0) when it is 0.
- R8: The address byte is captured at the rising clock edge where ale was high one edge before and is low now. At all other times it holds.
- R9: When built with HAS_CTRL = 0, Control reads 0, writes to it are ignored, and every pin stays in microcontroller I/O mode.
- R10: A write strobe without chip select, or chip select without a write strobe, leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Port window select |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register offset in the window |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the offset on addr |
| ale | input | 1 | Address latch enable |
| bus_addr | input | 8 | Bus address byte to capture |
| pld_out | input | W | Logic-array output value per pin |
| pld_oe | input | W | Logic-array output-enable term per pin |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables (1 drives) |

## Verification
A register write and a change of pin mode can land in the same clock edge. So can an address capture and a pin mode that is already showing the captured byte. The bench writes Control while address-output pins are live. It then moves the bus address with ale held low, and after that drops ale. It checks the pad values in the cycle after each edge against values worked out from the masks. A second port built without a Control register takes the same writes, and the bench confirms its pins stay in microcontroller I/O mode.

// File: rtl/cfg_io_pkg.sv
// Shared definitions for the configurable I/O port.
// Assumes a four-entry register window addressed by a 2-bit offset.
package cfg_io_pkg;
    typedef enum logic [1:0] {
        OFS_PIN_LEVEL = 2'd0,
        OFS_MODE      = 2'd1,
        OFS_OUT_VAL   = 2'd2,
        OFS_DRIVE_DIR = 2'd3
    } port_ofs_e;

    localparam int NIB_W = 4;
    localparam int BUS_AW = 8;
endpackage

// File: rtl/cfg_io_regs.sv
// Register file of the port: mode, output value and direction registers,
// a pad sampling register and the read-back mux.
// Assumes single-cycle writes qualified by cs and wr; reads are combinational.
module cfg_io_regs
    import cfg_io_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] rdata,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] oval_q,
    output logic [W-1:0] dir_q
);
    logic         wr_en;
    logic [W-1:0] lvl_q;

    assign wr_en = cs && wr;

    generate
        if (HAS_CTRL) begin : g_mode
            // Mode register update
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mode_q <= '0;
                else if (wr_en && addr == OFS_MODE)
                    mode_q <= wdata;
            end
        end else begin : g_nomode
            assign mode_q = '0;
        end
    endgenerate

    // Output value and direction register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oval_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (addr == OFS_OUT_VAL)   oval_q <= wdata;
            if (addr == OFS_DRIVE_DIR) dir_q  <= wdata;
        end
    end

    // Pad level sampling, once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= pad_in;
    end

    // Read-back mux
    always_comb begin
        case (addr)
            OFS_PIN_LEVEL: rdata = lvl_q;
            OFS_MODE:      rdata = mode_q;
            OFS_OUT_VAL:   rdata = oval_q;
            default:       rdata = dir_q;
        endcase
    end

    // R10
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> ($stable(mode_q) && $stable(oval_q) && $stable(dir_q)));

    // R2
    oval_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == OFS_OUT_VAL) |=> (oval_q == $past(wdata)));

    // R3
    level_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_q == $past(pad_in)));
endmodule

// File: rtl/cfg_io_addr_latch.sv
// Captures the bus address byte on the falling edge of the address latch
// enable, detected synchronously against the previous clock's ale value.
// Assumes ale is synchronous to clk.
module cfg_io_addr_latch
    import cfg_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic [BUS_AW-1:0] addr_byte
);
    logic ale_q;
    logic fall;

    assign fall = ale_q && !ale;

    // Previous ale value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ale_q <= 1'b0;
        else        ale_q <= ale;
    end

    // Address byte capture on ale fall
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_byte <= '0;
        else if (fall) addr_byte <= bus_addr;
    end

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(addr_byte));
endmodule

// File: rtl/cfg_io_pin_mux.sv
// Per-pin output selection. Each pin picks its value and enable from mode,
// direction and the build-time masks of logic-array outputs and enable terms.
// Assumes W is a multiple of four; nibble k covers pins 4k..4k+3.
module cfg_io_pin_mux
    import cfg_io_pkg::*;
#(
    parameter int               W       = 8,
    parameter logic [W-1:0]     ARR_DEF = 8'hF0,
    parameter logic [W-1:0]     OE_DEF  = 8'hC0,
    parameter logic [W/4-1:0]   NIB_HI  = 2'b01
) (
    input  logic [W-1:0]      mode_q,
    input  logic [W-1:0]      oval_q,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      pld_out,
    input  logic [W-1:0]      pld_oe,
    input  logic [BUS_AW-1:0] addr_byte,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam int NIB = i / NIB_W;
        localparam int POS = i % NIB_W;
        logic has_arr;
        logic has_oe;
        logic adr_bit;
        logic mcu_oe;
        logic arr_oe;

        assign has_arr = ARR_DEF[i];
        assign has_oe  = OE_DEF[i];
        assign adr_bit = NIB_HI[NIB] ? addr_byte[NIB_W + POS] : addr_byte[POS];
        assign mcu_oe  = has_oe ? pld_oe[i] : dir_q[i];
        assign arr_oe  = dir_q[i] && (has_oe ? pld_oe[i] : 1'b1);

        // Mode decode for this pin
        always_comb begin
            if (!mode_q[i]) begin
                pad_out[i] = oval_q[i];
                pad_oe[i]  = mcu_oe;
            end else if (has_arr) begin
                pad_out[i] = pld_out[i];
                pad_oe[i]  = arr_oe;
            end else begin
                pad_out[i] = adr_bit;
                pad_oe[i]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_io_port.sv
// Top of the configurable I/O port: register window, address capture and
// per-pin output selection.
// Assumes all inputs are synchronous to clk; pads are outside this block.
module cfg_io_port
    import cfg_io_pkg::*;
#(
    parameter int             W        = 8,
    parameter bit             HAS_CTRL = 1'b1,
    parameter logic [W-1:0]   ARR_DEF  = 8'hF0,
    parameter logic [W-1:0]   OE_DEF   = 8'hC0,
    parameter logic [W/4-1:0] NIB_HI   = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              ale,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [W-1:0]      pld_out,
    input  logic [W-1:0]      pld_oe,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    logic [W-1:0]      mode_q;
    logic [W-1:0]      oval_q;
    logic [W-1:0]      dir_q;
    logic [BUS_AW-1:0] addr_byte;

    cfg_io_regs #(.W(W), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr),
        .wdata(wdata), .pad_in(pad_in), .rdata(rdata),
        .mode_q(mode_q), .oval_q(oval_q), .dir_q(dir_q)
    );

    cfg_io_addr_latch u_alat (
        .clk(clk), .rst_n(rst_n), .ale(ale), .bus_addr(bus_addr),
        .addr_byte(addr_byte)
    );

    cfg_io_pin_mux #(.W(W), .ARR_DEF(ARR_DEF), .OE_DEF(OE_DEF), .NIB_HI(NIB_HI)) u_mux (
        .mode_q(mode_q), .oval_q(oval_q), .dir_q(dir_q),
        .pld_out(pld_out), .pld_oe(pld_oe), .addr_byte(addr_byte),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (!ARR_DEF[i]) begin : g_adr
            // R7
            addr_pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mode_q[i] |-> pad_oe[i]);
        end else begin : g_arr
            // R6
            arr_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q[i] && !dir_q[i]) |-> !pad_oe[i]);
        end
    end
endmodule

// File: tb/cfg_io_port_test.sv
// Scoreboard bench: the driver pushes expected values, the monitor pops and
// compares them at the falling clock edge.
module cfg_io_port_test;
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr = 1'b0, ale = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = '0, bus_addr = '0, pld_out = '0, pld_oe = '0, pad_in = '0;
    logic [7:0] rdata, pad_out, pad_oe, rdata_f, pad_out_f, pad_oe_f;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_io_port uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ale(ale), .bus_addr(bus_addr), .pld_out(pld_out),
        .pld_oe(pld_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    cfg_io_port #(.HAS_CTRL(1'b0)) uut_fixed (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata_f), .ale(ale), .bus_addr(bus_addr), .pld_out(pld_out),
        .pld_oe(pld_oe), .pad_in(pad_in), .pad_out(pad_out_f), .pad_oe(pad_oe_f)
    );

    function automatic logic [7:0] observe(int kind);
        case (kind)
            0: return rdata;
            1: return pad_out;
            2: return pad_oe;
            3: return rdata_f;
            4: return pad_out_f;
            default: return pad_oe_f;
        endcase
    endfunction

    // Monitor: compare all pending expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = q.pop_front();
            got = observe(it.kind);
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, got, it.exp);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push(int kind, logic [7:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // One clock: inputs already set; returns just after the rising edge
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic write_reg(logic [1:0] ofs, logic [7:0] v);
        cs = 1'b1; wr = 1'b1; addr = ofs; wdata = v;
        tick();
        cs = 1'b0; wr = 1'b0;
        settle();
    endtask

    task automatic read_chk(logic [1:0] ofs, logic [7:0] exp, logic [7:0] exp_f, string req);
        addr = ofs; #1;
        push(0, exp, req);
        push(3, exp_f, req);
        settle();
    endtask

    task automatic pads_chk(logic [7:0] o, logic [7:0] e, string req);
        push(1, o, req);
        push(2, e, req);
        settle();
    endtask

    initial begin
        #1;
        repeat (3) tick();
        settle();
        // R1: reset state
        read_chk(2'd1, 8'h00, 8'h00, "R1");
        read_chk(2'd2, 8'h00, 8'h00, "R1");
        read_chk(2'd3, 8'h00, 8'h00, "R1");
        pads_chk(8'h00, 8'h00, "R1");
        rst_n = 1'b1;
        tick(); settle();
        pads_chk(8'h00, 8'h00, "R1");

        // R2, R4, R5: microcontroller I/O mode
        pld_oe = 8'h40;
        write_reg(2'd2, 8'hA5);
        write_reg(2'd3, 8'h0F);
        pads_chk(8'hA5, 8'h4F, "R4 R5");
        read_chk(2'd2, 8'hA5, 8'hA5, "R2");
        read_chk(2'd3, 8'h0F, 8'h0F, "R2");
        pld_oe = 8'h80; #1;
        pads_chk(8'hA5, 8'h8F, "R5");
        pld_oe = 8'h40;

        // R3: pin level read, offset 0 write ignored
        pad_in = 8'h96;
        write_reg(2'd0, 8'h33);
        read_chk(2'd0, 8'h96, 8'h96, "R3");
        read_chk(2'd1, 8'h00, 8'h00, "R3");
        read_chk(2'd2, 8'hA5, 8'hA5, "R3");
        read_chk(2'd3, 8'h0F, 8'h0F, "R3");

        // R10: strobe without select, select without strobe
        cs = 1'b0; wr = 1'b1; addr = 2'd2; wdata = 8'h00;
        tick(); wr = 1'b0; settle();
        read_chk(2'd2, 8'hA5, 8'hA5, "R10");
        cs = 1'b1; wr = 1'b0; addr = 2'd3; wdata = 8'hFF;
        tick(); cs = 1'b0; settle();
        read_chk(2'd3, 8'h0F, 8'h0F, "R10");

        // R8: capture 0x3C on ale fall
        bus_addr = 8'h3C; ale = 1'b1;
        tick(); settle();
        ale = 1'b0;
        tick(); settle();

        // R6, R7, R9: modes on, upper pins tri-stated by direction 0
        pld_out = 8'h5A;
        write_reg(2'd1, 8'hFF);
        read_chk(2'd1, 8'hFF, 8'h00, "R2 R9");
        pads_chk(8'h53, 8'h0F, "R6 R7");
        push(4, 8'hA5, "R9");
        push(5, 8'h4F, "R9");
        settle();
        write_reg(2'd3, 8'hFF);
        pads_chk(8'h53, 8'h7F, "R6");
        push(4, 8'hA5, "R9");
        push(5, 8'h7F, "R9");
        settle();

        // R8: bus change with ale low holds; ale high holds; ale fall captures
        bus_addr = 8'hE1;
        tick(); settle();
        pads_chk(8'h53, 8'h7F, "R8");
        ale = 1'b1;
        tick(); settle();
        pads_chk(8'h53, 8'h7F, "R8");
        ale = 1'b0;
        tick();
        pads_chk(8'h5E, 8'h7F, "R7 R8");

        // R4, R7: mixed modes, upper pins back to microcontroller I/O
        write_reg(2'd1, 8'h0F);
        pads_chk(8'hAE, 8'h7F, "R4 R7");
        pld_oe = 8'h00; #1;
        pads_chk(8'hAE, 8'h3F, "R5");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule